// File: doc/BRIEF.md
# Serial Command and Response Framer

The framer sits on the device side of a two-wire serial link, one clock line and one data line, that carries 16-bit words MSb first. It collects a command from the host and passes the complete command to a backend in one parallel handoff. It then reports the outcome as a framed response. The first word of each command is a header. Its upper four bits hold an opcode, and its lower twelve bits hold the total word count of the command, header included. The framer shifts in exactly that many words.

The host releases the data line once the command is complete. The framer then drives the line high to show that it is busy. It holds the line high until the backend reports completion, and then pulls it low. When the host sees the line low, it clocks out a two-word response header followed by any data words. The framer answers some commands itself, without calling the backend: an opcode outside the implemented set, and a length field of zero or greater than the receive capacity.

The serial clock reaches the block as a one-cycle `sck_pulse` strobe that has already been synchronised to `clk`.

Top module: `pex_framer`

## Requirements
- R1: After reset the data line is released (`sdo_en`=0) and `cmd_go` is low.
- R2: A header word carries the opcode in bits 15:12 and the total command length in bits 11:0, header included. After the last word arrives, `cmd_go` pulses for one cycle. During that pulse `cmd_op` and `cmd_len` hold the header fields, and payload word k (the word after the header counts as k=0) sits on `cmd_payload[16k+15:16k]`.
- R3: From the end of the command until the backend raises `be_done`, the framer drives the line high (`sdo_en`=1, `sdo`=1). Serial clock pulses in this interval have no effect on the response.
- R4: After completion the line is driven low. It stays low until the host gives one serial clock pulse, and the response starts after that pulse.
- R5: Response word 0 is {status[3:0], command opcode[3:0], query code[7:0]}. Response word 1 is the response length, equal to 2 plus the data word count. The data words follow. Each bit is presented on `sdo` before the serial clock pulse that advances it, MSb first.
- R6: Status is 0x1 (pass) when `be_fail` is low and 0x2 (fail) when it is high. The query code is `be_qcode`. For example, a passing program command with opcode 5 gives 0x1500, 0x0002.
- R7: An opcode whose bit is clear in `IMPL_MASK` (by default opcodes 0xB to 0xF) gives the response 0x3 status, the echoed opcode and query 0x00, then a length of 0x0002. No `cmd_go` is issued for it.
- R8: A length field of 0 or greater than `MAX_WORDS` (default 8) ends reception after the header. It gives a fail response, {0x2, opcode, 0x00} then 0x0002, and no `cmd_go`.
- R9: The backend may return up to `MAX_DATA` data words (`be_ndata`, word k on `be_data[16k+15:16k]`). The line is released after the last response bit, and the next command is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_pulse | input | 1 | One-cycle strobe per serial clock edge |
| sdi | input | 1 | Data line value from host |
| sdo | output | 1 | Data line value driven by framer |
| sdo_en | output | 1 | Framer drives the data line |
| cmd_go | output | 1 | One-cycle command handoff strobe |
| cmd_op | output | 4 | Command opcode |
| cmd_len | output | 12 | Command length field |
| cmd_payload | output | 16*(MAX_WORDS-1) | Payload words after the header |
| be_done | input | 1 | Backend finished the command |
| be_fail | input | 1 | Backend reports failure |
| be_qcode | input | 8 | Query code for the response header |
| be_ndata | input | clog2(MAX_DATA+1) | Number of response data words |
| be_data | input | 16*MAX_DATA | Response data words |

## Verification
The situation hardest to reach from the ports is a serial clock pulse that arrives while the line signals busy. Such a pulse must be ignored. If it were not, it would be taken as the host's start-of-response pulse and would shift every response bit by one. The bench holds the backend answer back for about twenty cycles and fires two pulses, with random data, while it watches the line held high. Only after that does it read the response and compare it bit by bit. Random commands of every legal length, mixed with the unknown-opcode and bad-length cases, check that bad-length commands stop reception after the header and that the receive counter returns to the header state for the next command.

// File: rtl/pex_pkg.sv
package pex_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [3:0] {
        RS_PASS = 4'h1,
        RS_FAIL = 4'h2,
        RS_NACK = 4'h3
    } rsp_stat_e;

    typedef enum logic [2:0] {
        ST_RX_HDR,
        ST_RX_BODY,
        ST_DISPATCH,
        ST_BUSY,
        ST_READY,
        ST_TX
    } fr_state_e;

    typedef struct packed {
        logic [3:0]  op;
        logic [11:0] len;
    } cmd_hdr_t;

    function automatic logic [WORD_W-1:0] rsp_head(rsp_stat_e st, logic [3:0] op, logic [7:0] q);
        return {st, op, q};
    endfunction

endpackage

// File: rtl/pex_deser.sv
module pex_deser #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         word_vld
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt;
    logic [W-1:0]  sh;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt      <= '0;
            sh       <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (shift) begin
                sh <= {sh[W-2:0], din};
                if (cnt == CW'(W-1)) begin
                    cnt      <= '0;
                    word_vld <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign word = sh;
endmodule

// File: rtl/pex_rsp_sel.sv
module pex_rsp_sel #(
    parameter int MAX_DATA = 4,
    parameter int IW       = 3
) (
    input  logic [15:0]            head0,
    input  logic [15:0]            head1,
    input  logic [16*MAX_DATA-1:0] data,
    input  logic [IW-1:0]          idx,
    output logic [15:0]            word
);
    localparam int NW = MAX_DATA + 2;

    logic [15:0] words [NW];

    assign words[0] = head0;
    assign words[1] = head1;

    for (genvar k = 0; k < MAX_DATA; k++) begin : g_data
        assign words[k+2] = data[16*k +: 16];
    end

    always_comb begin
        word = '0;
        for (int k = 0; k < NW; k++) begin
            if (idx == IW'(k)) word = words[k];
        end
    end
endmodule

// File: rtl/pex_framer.sv
module pex_framer
    import pex_pkg::*;
#(
    parameter int          MAX_WORDS = 8,
    parameter int          MAX_DATA  = 4,
    parameter logic [15:0] IMPL_MASK = 16'h07FF,
    localparam int         PAYW      = MAX_WORDS - 1,
    localparam int         NDW       = $clog2(MAX_DATA + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sck_pulse,
    input  logic                   sdi,
    output logic                   sdo,
    output logic                   sdo_en,
    output logic                   cmd_go,
    output logic [3:0]             cmd_op,
    output logic [11:0]            cmd_len,
    output logic [16*PAYW-1:0]     cmd_payload,
    input  logic                   be_done,
    input  logic                   be_fail,
    input  logic [7:0]             be_qcode,
    input  logic [NDW-1:0]         be_ndata,
    input  logic [16*MAX_DATA-1:0] be_data
);
    localparam int IW = $clog2(MAX_DATA + 2);

    fr_state_e             state;
    cmd_hdr_t              hdr;
    logic [11:0]           wcnt;
    logic [15:0]           pay [PAYW];
    logic                  local_rsp;
    rsp_stat_e             stat;
    logic [7:0]            qcode;
    logic [NDW-1:0]        ndata;
    logic [16*MAX_DATA-1:0] dbuf;
    logic [IW-1:0]         widx;
    logic [3:0]            bitc;

    logic                  rx_en, rx_clr, wvld;
    logic [15:0]           rx_word, tx_word;
    logic                  op_unknown, len_bad;
    cmd_hdr_t              rx_hdr;

    assign rx_en  = (state == ST_RX_HDR) || (state == ST_RX_BODY);
    assign rx_clr = !rx_en;
    assign rx_hdr = cmd_hdr_t'(rx_word);

    pex_deser #(.W(16)) u_deser (
        .clk      (clk),
        .rst      (rst),
        .clr      (rx_clr),
        .shift    (sck_pulse && rx_en),
        .din      (sdi),
        .word     (rx_word),
        .word_vld (wvld)
    );

    assign op_unknown = !IMPL_MASK[hdr.op];
    assign len_bad    = (hdr.len == 12'd0) || (hdr.len > 12'(MAX_WORDS));

    pex_rsp_sel #(.MAX_DATA(MAX_DATA), .IW(IW)) u_sel (
        .head0 (rsp_head(stat, hdr.op, qcode)),
        .head1 (16'(ndata) + 16'd2),
        .data  (dbuf),
        .idx   (widx),
        .word  (tx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RX_HDR;
            hdr       <= '0;
            wcnt      <= '0;
            local_rsp <= 1'b0;
            stat      <= RS_PASS;
            qcode     <= '0;
            ndata     <= '0;
            dbuf      <= '0;
            widx      <= '0;
            bitc      <= '0;
            for (int k = 0; k < PAYW; k++) pay[k] <= '0;
        end else begin
            case (state)
                ST_RX_HDR: if (wvld) begin
                    hdr  <= rx_hdr;
                    wcnt <= 12'd1;
                    if (rx_hdr.len <= 12'd1 || rx_hdr.len > 12'(MAX_WORDS))
                        state <= ST_DISPATCH;
                    else
                        state <= ST_RX_BODY;
                end
                ST_RX_BODY: if (wvld) begin
                    for (int k = 0; k < PAYW; k++)
                        if (wcnt == 12'(k + 1)) pay[k] <= rx_word;
                    wcnt <= wcnt + 12'd1;
                    if (wcnt + 12'd1 == hdr.len) state <= ST_DISPATCH;
                end
                ST_DISPATCH: begin
                    local_rsp <= op_unknown || len_bad;
                    stat      <= op_unknown ? RS_NACK : RS_FAIL;
                    qcode     <= '0;
                    ndata     <= '0;
                    state     <= ST_BUSY;
                end
                ST_BUSY: begin
                    if (local_rsp) begin
                        state <= ST_READY;
                    end else if (be_done) begin
                        stat  <= be_fail ? RS_FAIL : RS_PASS;
                        qcode <= be_qcode;
                        ndata <= (be_ndata > NDW'(MAX_DATA)) ? NDW'(MAX_DATA) : be_ndata;
                        dbuf  <= be_data;
                        state <= ST_READY;
                    end
                end
                ST_READY: if (sck_pulse) begin
                    widx  <= '0;
                    bitc  <= '0;
                    state <= ST_TX;
                end
                ST_TX: if (sck_pulse) begin
                    if (bitc == 4'd15) begin
                        bitc <= '0;
                        if (32'(widx) == 32'(ndata) + 1) state <= ST_RX_HDR;
                        else widx <= widx + 1'b1;
                    end else begin
                        bitc <= bitc + 4'd1;
                    end
                end
                default: state <= ST_RX_HDR;
            endcase
        end
    end

    assign cmd_go  = (state == ST_DISPATCH) && !op_unknown && !len_bad;
    assign cmd_op  = hdr.op;
    assign cmd_len = hdr.len;

    for (genvar k = 0; k < PAYW; k++) begin : g_pay
        assign cmd_payload[16*k +: 16] = pay[k];
    end

    always_comb begin
        sdo_en = 1'b1;
        sdo    = 1'b0;
        case (state)
            ST_DISPATCH, ST_BUSY: sdo = 1'b1;
            ST_READY:             sdo = 1'b0;
            ST_TX:                sdo = tx_word[4'd15 - bitc];
            default:              sdo_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/pex_framer_chk.sv
module pex_framer_chk #(
    parameter int          MAX_WORDS = 8,
    parameter logic [15:0] IMPL_MASK = 16'h07FF
) (
    input logic        clk,
    input logic        rst,
    input logic        sdo,
    input logic        sdo_en,
    input logic        cmd_go,
    input logic [3:0]  cmd_op,
    input logic [11:0] cmd_len
);
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmd_go |=> !cmd_go);                                            // R2
    AST_GO_THEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        cmd_go |=> (sdo_en && sdo));                                    // R3
    AST_DRIVE_STARTS_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_en) |-> sdo);                                         // R3
    AST_GO_KNOWN_OP: assert property (@(posedge clk) disable iff (rst)
        cmd_go |-> IMPL_MASK[cmd_op]);                                  // R7
    AST_GO_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cmd_go |-> (cmd_len != 12'd0 && cmd_len <= 12'(MAX_WORDS)));    // R8
    AST_GO_LINE_HELD: assert property (@(posedge clk) disable iff (rst)
        cmd_go |-> sdo_en);                                             // R3
endmodule

bind pex_framer pex_framer_chk #(.MAX_WORDS(MAX_WORDS), .IMPL_MASK(IMPL_MASK)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sdo     (sdo),
    .sdo_en  (sdo_en),
    .cmd_go  (cmd_go),
    .cmd_op  (cmd_op),
    .cmd_len (cmd_len)
);

// File: tb/pex_framer_tb.sv
module pex_framer_tb;
    localparam int MW  = 8;
    localparam int MD  = 4;
    localparam int NDW = $clog2(MD + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck_pulse = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_en, cmd_go;
    logic [3:0] cmd_op;
    logic [11:0] cmd_len;
    logic [16*(MW-1)-1:0] cmd_payload;
    logic be_done = 1'b0;
    logic be_fail = 1'b0;
    logic [7:0] be_qcode = '0;
    logic [NDW-1:0] be_ndata = '0;
    logic [16*MD-1:0] be_data = '0;

    int checks = 0;
    int failures = 0;
    int go_cnt = 0;
    logic [3:0] cap_op;
    logic [11:0] cap_len;
    logic [16*(MW-1)-1:0] cap_pay;
    logic [15:0] pay [MW];

    always #2.5 clk = ~clk;

    pex_framer u_dut (
        .clk(clk), .rst(rst), .sck_pulse(sck_pulse), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en), .cmd_go(cmd_go), .cmd_op(cmd_op),
        .cmd_len(cmd_len), .cmd_payload(cmd_payload), .be_done(be_done),
        .be_fail(be_fail), .be_qcode(be_qcode), .be_ndata(be_ndata),
        .be_data(be_data)
    );

    function automatic logic exp_fail(logic [3:0] op, int len, logic [15:0] p0);
        return (len > 1) && p0[15];
    endfunction
    function automatic logic [7:0] exp_q(logic [3:0] op, int len, logic [15:0] p0);
        if (op == 4'hA) return 8'h0F;
        return (len > 1) ? p0[7:0] : 8'h00;
    endfunction
    function automatic int exp_nd(int len);
        return (len - 1 > MD) ? MD : len - 1;
    endfunction

    // backend model
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_go) begin
                go_cnt++;
                cap_op  = cmd_op;
                cap_len = cmd_len;
                cap_pay = cmd_payload;
                be_fail  = exp_fail(cmd_op, int'(cmd_len), cmd_payload[15:0]);
                be_qcode = exp_q(cmd_op, int'(cmd_len), cmd_payload[15:0]);
                be_ndata = NDW'(exp_nd(int'(cmd_len)));
                for (int k = 0; k < MD; k++) be_data[16*k +: 16] = ~cmd_payload[16*k +: 16];
                repeat (20) @(negedge clk);
                be_done = 1'b1;
                @(negedge clk);
                be_done = 1'b0;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic b);
        @(negedge clk);
        sdi = b;
        sck_pulse = 1'b1;
        @(negedge clk);
        sck_pulse = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) pulse(w[i]);
    endtask

    task automatic recv_word(output logic [15:0] w);
        w = '0;
        for (int i = 0; i < 16; i++) begin
            w = {w[14:0], sdo};
            pulse(1'b0);
        end
    endtask

    // op, len field, words actually sent, whether the backend is expected
    task automatic run_cmd(input logic [3:0] op, input int len, input int nsend,
                           input logic dispatched, input logic [15:0] exp_w0, input string tag);
        int go_before;
        int t;
        logic [15:0] w0, w1, wd;
        int nd;
        go_before = go_cnt;
        send_word({op, 12'(len)});
        for (int k = 1; k < nsend; k++) send_word(pay[k-1]);
        if (dispatched) begin
            // R3: clock pulses while busy must be ignored
            for (int k = 0; k < 2; k++) begin
                chk(sdo_en && sdo, "R3 busy high", {30'd0, sdo_en, sdo}, 32'd3);
                pulse(1'($urandom));
            end
        end
        t = 0;
        while (!(sdo_en && !sdo) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 2000, "R4 ready low", t, 0);
        repeat (4) @(negedge clk);
        chk(sdo_en && !sdo, "R4 low held", {30'd0, sdo_en, sdo}, 32'd2);
        pulse(1'b0);
        recv_word(w0);
        recv_word(w1);
        chk(w0 == exp_w0, {tag, " word0"}, w0, exp_w0);
        nd = dispatched ? exp_nd(len) : 0;
        chk(w1 == 16'(nd + 2), "R5 length word", w1, nd + 2);
        for (int k = 0; k < nd; k++) begin
            recv_word(wd);
            chk(wd == ~pay[k], "R9 data word", wd, ~pay[k]);
        end
        @(negedge clk);
        chk(!sdo_en, "R9 line released", sdo_en, 0);
        chk((go_cnt - go_before) == (dispatched ? 1 : 0), "R7/R8 handoff count",
            go_cnt - go_before, dispatched ? 1 : 0);
        if (dispatched) begin
            chk(cap_op == op && cap_len == 12'(len), "R2 header fields",
                {cap_op, cap_len}, {op, 12'(len)});
            for (int k = 0; k < len - 1; k++)
                chk(cap_pay[16*k +: 16] == pay[k], "R2 payload word", cap_pay[16*k +: 16], pay[k]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [3:0] op;
        int len;
        logic [15:0] e0;
        void'($urandom(32'd1234));
        for (int k = 0; k < MW; k++) pay[k] = '0;
        repeat (4) @(negedge clk);
        chk(!sdo_en && !cmd_go, "R1 reset state", {sdo_en, cmd_go}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!sdo_en && !cmd_go, "R1 after reset", {sdo_en, cmd_go}, 0);

        run_cmd(4'h5, 1, 1, 1'b1, 16'h1500, "R6 program pass");
        run_cmd(4'hA, 1, 1, 1'b1, 16'h1A0F, "R6 blank query");
        run_cmd(4'hB, 1, 1, 1'b0, 16'h3B00, "R7 unknown op");
        run_cmd(4'hF, 1, 1, 1'b0, 16'h3F00, "R7 unknown op F");
        run_cmd(4'h3, 0, 1, 1'b0, 16'h2300, "R8 zero length");
        run_cmd(4'h2, MW + 1, 1, 1'b0, 16'h2200, "R8 long length");
        pay[0] = 16'h8042; pay[1] = 16'h1234;
        run_cmd(4'h4, 3, 3, 1'b1, 16'h2442, "R6 fail status");
        for (int k = 0; k < MW; k++) pay[k] = 16'($urandom);
        run_cmd(4'h7, MW, MW, 1'b1,
                {exp_fail(4'h7, MW, pay[0]) ? 4'h2 : 4'h1, 4'h7, exp_q(4'h7, MW, pay[0])},
                "R5 full length");

        for (int n = 0; n < 20; n++) begin
            op  = 4'($urandom_range(0, 10));
            len = $urandom_range(1, MW);
            for (int k = 0; k < MW; k++) pay[k] = 16'($urandom);
            e0 = {exp_fail(op, len, pay[0]) ? 4'h2 : 4'h1, op, exp_q(op, len, pay[0])};
            run_cmd(op, len, len, 1'b1, e0, "R5 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule